// File: doc/BRIEF.md
# One-Wire Slave Bit Transceiver

This block is the bit-level front end of a slave on a single open-drain data line. It watches the sampled line and measures each low period in microsecond ticks. A long low followed by a release is taken as a bus reset, and the block answers it with a presence pulse. A short low opens a time slot. In a write slot the block samples the line at a fixed point and reports the bit upward. In a read slot it holds the line low for a logic 0 supplied by the upper layer, and leaves it alone for a logic 1.

All timing is counted on a one-microsecond clock-enable tick. A static speed-select input chooses between the standard and the overdrive threshold sets. The selection is captured only while the bus is idle. One low-time counter serves several purposes: the slot sample point, the slot drive hold, the transaction abort threshold, the reset threshold and a multi-second sleep detector. The line passes through a two-flop synchroniser and a glitch filter before any edge is taken. Byte framing and command decoding belong to the layer above.

Top module: `ow_slave_phy`

## Requirements
- R1: While and after synchronous reset, `pull_o`, `rx_valid`, `bit_used`, `rst_det`, `abort_o` and `sleep_req` are all 0.
- R2: A filtered low that has lasted at least 470 ticks (standard) or 46 ticks (overdrive) when the line rises gives one `rst_det` pulse. A shorter low gives none.
- R3: After a detected reset, the block waits 30 ticks (standard) or 3 ticks (overdrive) and then drives `pull_o` high for 120 ticks (standard) or 16 ticks (overdrive). The bus therefore sees a presence wait within 15–60 / 2–6 µs and a presence low within 60–240 / 8–24 µs.
- R4: In a write slot (`rd_slot`=0 at the falling edge), the line is sampled 30 ticks (standard) or 3 ticks (overdrive) after the detected fall. One `rx_valid` pulse carries `rx_bit`, where 1 means the line was high. A read slot produces no `rx_valid`.
- R5: In a read slot with `tx_bit`=0, `pull_o` is high from the detected fall until 40 ticks (standard) or 4 ticks (overdrive) have passed. With `tx_bit`=1 it stays low. In both cases the line is released before the minimum slot end of 60 / 6 µs. A write slot never drives.
- R6: Every slot start, meaning a falling edge seen while idle, gives exactly one `bit_used` pulse. `rd_slot` and `tx_bit` are captured in that cycle.
- R7: A low period reaching 120 ticks (standard) or 16 ticks (overdrive) gives exactly one `abort_o` pulse.
- R8: With `sleep_en`=1, a low period reaching `SLEEP_US` ticks gives exactly one `sleep_req` pulse. With `sleep_en`=0 there is none.
- R9: `speed_od`=1 selects the overdrive set and 0 selects standard. The value is captured only while the block is idle.
- R10: A low shorter than `FILT_LEN` clock cycles is filtered out and starts no slot.
- R11: The block's own presence pulse, and the line recovery after it, never start a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle clock enable every microsecond |
| line_i | input | 1 | Raw bus level (1 = released) |
| speed_od | input | 1 | 1 = overdrive timing, 0 = standard |
| sleep_en | input | 1 | Allows the long-low sleep request |
| rd_slot | input | 1 | Next slot is a read slot |
| tx_bit | input | 1 | Bit to present in the next read slot |
| pull_o | output | 1 | 1 = drive the bus low (open drain) |
| bit_used | output | 1 | Pulse: slot started, rd_slot/tx_bit taken |
| rx_bit | output | 1 | Bit decoded from the last write slot |
| rx_valid | output | 1 | Pulse: rx_bit is new |
| rst_det | output | 1 | Pulse: bus reset detected |
| abort_o | output | 1 | Pulse: low exceeded the abort limit |
| sleep_req | output | 1 | Pulse: low exceeded the sleep limit |

## Verification
The abort pulse and the sleep request come from the same counter and can fire in the same clock cycle. The bench sets the sleep limit equal to the standard abort limit of 120 ticks, holds the line low for 130 ticks with sleep enabled, and requires both pulses to appear in one identical cycle. The same low period with sleep disabled must still abort but give no sleep request.

// File: rtl/ow_phy_pkg.sv
package ow_phy_pkg;
  localparam int TW = 10;

  typedef struct packed {
    logic [TW-1:0] smp;
    logic [TW-1:0] hold;
    logic [TW-1:0] rst;
    logic [TW-1:0] abrt;
    logic [TW-1:0] pwait;
    logic [TW-1:0] plen;
  } ow_tset_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SLOT, ST_LOW, ST_PWAIT, ST_PRES, ST_REC
  } ow_st_e;

  function automatic ow_tset_t ow_tset(input logic od);
    ow_tset_t t;
    if (od) begin
      t.smp = 10'd3;   t.hold = 10'd4;   t.rst = 10'd46;
      t.abrt = 10'd16; t.pwait = 10'd3;  t.plen = 10'd16;
    end else begin
      t.smp = 10'd30;   t.hold = 10'd40;  t.rst = 10'd470;
      t.abrt = 10'd120; t.pwait = 10'd30; t.plen = 10'd120;
    end
    return t;
  endfunction
endpackage

// File: rtl/ow_line_filter.sv
module ow_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  localparam int FW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [FW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      run_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == line_o) begin
        run_q <= '0;
      end else if (run_q == FW'(FILT_LEN - 1)) begin
        run_q  <= '0;
        line_o <= sync_q[1];
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ow_low_timer.sv
module ow_low_timer #(
  parameter int CW = 21
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (run && tick && (cnt != {CW{1'b1}})) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ow_slave_phy.sv
module ow_slave_phy
  import ow_phy_pkg::*;
#(
  parameter int FILT_LEN = 3,
  parameter int SLEEP_US = 2000000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_us,
  input  logic line_i,
  input  logic speed_od,
  input  logic sleep_en,
  input  logic rd_slot,
  input  logic tx_bit,
  output logic pull_o,
  output logic bit_used,
  output logic rx_bit,
  output logic rx_valid,
  output logic rst_det,
  output logic abort_o,
  output logic sleep_req
);
  localparam int SW = $clog2(SLEEP_US + 1);
  localparam int CW = (SW > TW) ? SW : TW;

  logic          line_f, line_q, fall, rise;
  logic [CW-1:0] cnt;
  logic          cnt_run, cnt_clr;
  logic          spd_q, rd_q, smp_done, abrt_done, slp_done;
  ow_st_e        st, st_n;
  ow_tset_t      tm;
  logic ev_slot, ev_smp, ev_rel, ev_abort, ev_sleep, ev_rst, ev_pon, ev_poff;

  ow_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .line_i(line_i), .line_o(line_f)
  );

  ow_low_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .tick(tick_us), .run(cnt_run), .clr(cnt_clr), .cnt(cnt)
  );

  assign fall = line_q & ~line_f;
  assign rise = ~line_q & line_f;
  assign tm   = ow_tset(spd_q);
  assign cnt_run = (st == ST_SLOT) || (st == ST_LOW) || (st == ST_PWAIT) || (st == ST_PRES);

  always_comb begin
    st_n = st;
    cnt_clr = 1'b0;
    ev_slot = 1'b0; ev_smp = 1'b0; ev_rel = 1'b0; ev_abort = 1'b0;
    ev_sleep = 1'b0; ev_rst = 1'b0; ev_pon = 1'b0; ev_poff = 1'b0;
    case (st)
      ST_IDLE: if (fall) begin
        st_n = ST_SLOT; cnt_clr = 1'b1; ev_slot = 1'b1;
      end
      ST_SLOT: begin
        if (!smp_done && (cnt >= CW'(tm.smp))) ev_smp = 1'b1;
        if (cnt >= CW'(tm.hold)) begin
          ev_rel = 1'b1;
          st_n = line_f ? ST_IDLE : ST_LOW;
        end
      end
      ST_LOW: begin
        if (!abrt_done && (cnt >= CW'(tm.abrt))) ev_abort = 1'b1;
        if (sleep_en && !slp_done && (cnt >= CW'(SLEEP_US))) ev_sleep = 1'b1;
        if (rise) begin
          if (cnt >= CW'(tm.rst)) begin
            ev_rst = 1'b1; st_n = ST_PWAIT; cnt_clr = 1'b1;
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      ST_PWAIT: if (cnt >= CW'(tm.pwait)) begin
        ev_pon = 1'b1; st_n = ST_PRES; cnt_clr = 1'b1;
      end
      ST_PRES: if (cnt >= CW'(tm.plen)) begin
        ev_poff = 1'b1; st_n = ST_REC;
      end
      ST_REC: if (line_f) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      line_q    <= 1'b1;
      spd_q     <= 1'b0;
      rd_q      <= 1'b0;
      smp_done  <= 1'b0;
      abrt_done <= 1'b0;
      slp_done  <= 1'b0;
      pull_o    <= 1'b0;
      bit_used  <= 1'b0;
      rx_bit    <= 1'b0;
      rx_valid  <= 1'b0;
      rst_det   <= 1'b0;
      abort_o   <= 1'b0;
      sleep_req <= 1'b0;
    end else begin
      st     <= st_n;
      line_q <= line_f;
      if (st == ST_IDLE) spd_q <= speed_od;
      if (ev_slot) begin
        rd_q      <= rd_slot;
        smp_done  <= 1'b0;
        abrt_done <= 1'b0;
        slp_done  <= 1'b0;
      end
      if (ev_smp)   smp_done  <= 1'b1;
      if (ev_abort) abrt_done <= 1'b1;
      if (ev_sleep) slp_done  <= 1'b1;
      if ((ev_slot && rd_slot && !tx_bit) || ev_pon) pull_o <= 1'b1;
      else if (ev_rel || ev_poff)                    pull_o <= 1'b0;
      if (ev_smp && !rd_q) rx_bit <= line_f;
      rx_valid  <= ev_smp && !rd_q;
      bit_used  <= ev_slot;
      rst_det   <= ev_rst;
      abort_o   <= ev_abort;
      sleep_req <= ev_sleep;
    end
  end
endmodule

// File: rtl/ow_slave_phy_chk.sv
module ow_slave_phy_chk (
  input logic clk,
  input logic rst,
  input logic sleep_en,
  input logic pull_o,
  input logic bit_used,
  input logic rx_valid,
  input logic rst_det,
  input logic abort_o,
  input logic sleep_req
);
  // R6 / R11: a slot never starts while the block itself holds the line
  p_start_undriven_r11: assert property (@(posedge clk) disable iff (rst)
    bit_used |-> !$past(pull_o));
  // R4: a decoded write bit never comes from a driven slot
  p_write_no_drive_r5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !pull_o);
  // R3: presence does not begin on the releasing edge of the reset
  p_presence_delayed_r3: assert property (@(posedge clk) disable iff (rst)
    rst_det |-> !pull_o);
  // R7: abort is a single-cycle pulse
  p_abort_single_r7: assert property (@(posedge clk) disable iff (rst)
    abort_o |=> !abort_o);
  // R8: sleep only when enabled, and as a single pulse
  p_sleep_gated_r8: assert property (@(posedge clk) disable iff (rst)
    sleep_req |-> $past(sleep_en));
  p_sleep_single_r8: assert property (@(posedge clk) disable iff (rst)
    sleep_req |=> !sleep_req);
  // R2 / R4 / R6: slot start, sample and reset events are exclusive
  p_events_excl_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_valid, bit_used, rst_det}));
endmodule

bind ow_slave_phy ow_slave_phy_chk u_chk (
  .clk(clk), .rst(rst), .sleep_en(sleep_en), .pull_o(pull_o),
  .bit_used(bit_used), .rx_valid(rx_valid), .rst_det(rst_det),
  .abort_o(abort_o), .sleep_req(sleep_req)
);

// File: tb/ow_slave_phy_test.sv
`timescale 1ns/1ps
module ow_slave_phy_test;
  localparam int TICK_DIV = 5;
  localparam int SLP = 120;
  localparam int NV = 10;
  // {od, rd, bit}
  localparam logic [2:0] VEC [NV] = '{3'b001, 3'b000, 3'b010, 3'b011, 3'b100,
                                      3'b101, 3'b110, 3'b111, 3'b000, 3'b110};

  logic clk = 1'b0, rst = 1'b1, tick_us = 1'b0;
  logic mlow = 1'b0, speed_od = 1'b0, sleep_en = 1'b0, rd_slot = 1'b0, tx_bit = 1'b1;
  logic line, pull_o, bit_used, rx_bit, rx_valid, rst_det, abort_o, sleep_req;
  int n_chk = 0, n_fail = 0;
  int tdiv = 0, tcnt = 0, cyc = 0;
  int n_used = 0, n_rxv = 0, n_rst = 0, n_abort = 0, n_sleep = 0;
  int pr_t = 0, pf_t = 0, abort_cyc = -1, sleep_cyc = -2;
  logic last_rx = 1'b0, pull_q = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign line = ~(mlow | pull_o);

  ow_slave_phy #(.FILT_LEN(3), .SLEEP_US(SLP)) uut (
    .clk(clk), .rst(rst), .tick_us(tick_us), .line_i(line), .speed_od(speed_od),
    .sleep_en(sleep_en), .rd_slot(rd_slot), .tx_bit(tx_bit), .pull_o(pull_o),
    .bit_used(bit_used), .rx_bit(rx_bit), .rx_valid(rx_valid), .rst_det(rst_det),
    .abort_o(abort_o), .sleep_req(sleep_req)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    tick_us <= (tdiv == TICK_DIV - 1);
    if (tick_us) tcnt <= tcnt + 1;
    pull_q <= pull_o;
    if (pull_o && !pull_q) pr_t <= tcnt;
    if (!pull_o && pull_q) pf_t <= tcnt;
    if (bit_used) n_used <= n_used + 1;
    if (rx_valid) begin n_rxv <= n_rxv + 1; last_rx <= rx_bit; end
    if (rst_det) n_rst <= n_rst + 1;
    if (abort_o) begin n_abort <= n_abort + 1; abort_cyc <= cyc; end
    if (sleep_req) begin n_sleep <= n_sleep + 1; sleep_cyc <= cyc; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!tick_us);
    end
  endtask

  task automatic do_reset(input logic od, input int lowlen);
    int r0, u0, t0;
    speed_od = od;
    wt(2);
    r0 = n_rst;
    mlow = 1'b1; wt(lowlen); mlow = 1'b0;
    t0 = tcnt; u0 = n_used;
    wt(od ? 40 : 350);
    chk(n_rst == r0 + 1, "R2 reset pulse", n_rst - r0, 1);
    chk((pr_t - t0) >= (od ? 2 : 15) && (pr_t - t0) <= (od ? 6 : 60),
        od ? "R3 od presence wait" : "R3 std presence wait", pr_t - t0, od ? 4 : 31);
    chk((pf_t - pr_t) >= (od ? 8 : 60) && (pf_t - pr_t) <= (od ? 24 : 240),
        od ? "R3 R9 od presence len" : "R3 std presence len", pf_t - pr_t, od ? 16 : 120);
    chk(n_used == u0, "R11 presence starts no slot", n_used - u0, 0);
  endtask

  task automatic do_slot(input logic od, input logic rd, input logic b);
    int u0, v0, lo, tot, hl, st, en;
    logic seen;
    rd_slot = rd; tx_bit = b;
    u0 = n_used; v0 = n_rxv;
    if (!rd) begin
      lo  = b ? (od ? 1 : 5) : (od ? 8 : 70);
      tot = od ? 10 : 80;
      mlow = 1'b1; wt(lo); mlow = 1'b0; wt(tot - lo);
      chk(n_rxv == v0 + 1, "R4 one rx_valid per write slot", n_rxv - v0, 1);
      chk(last_rx == b, "R4 write bit value", int'(last_rx), int'(b));
    end else begin
      hl = od ? 2 : 5; st = od ? 3 : 13; en = od ? 8 : 60;
      mlow = 1'b1; wt(hl); mlow = 1'b0; wt(st - hl);
      seen = line;
      chk(seen == b, "R5 read slot bus level", int'(seen), int'(b));
      wt(en - st);
      chk(pull_o == 1'b0, "R5 released before slot end", int'(pull_o), 0);
      wt(2);
      chk(n_rxv == v0, "R4 no rx_valid in read slot", n_rxv - v0, 0);
    end
    chk(n_used == u0 + 1, "R6 one bit_used per slot", n_used - u0, 1);
    rd_slot = 1'b0; tx_bit = 1'b1;
  endtask

  initial begin
    int a0, s0, r0, u0;
    repeat (5) @(negedge clk);
    chk(pull_o == 1'b0 && rx_valid == 1'b0 && bit_used == 1'b0, "R1 outputs in reset",
        int'(pull_o) + int'(rx_valid) + int'(bit_used), 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk(n_used + n_rxv + n_rst + n_abort + n_sleep == 0 && pull_o == 1'b0,
        "R1 quiet after reset", n_used + n_rxv + n_rst + n_abort + n_sleep, 0);

    do_reset(1'b0, 500);
    do_reset(1'b1, 55);

    for (int i = 0; i < NV; i++) begin
      speed_od = VEC[i][2];
      wt(3);
      do_slot(VEC[i][2], VEC[i][1], VEC[i][0]);
      wt(3);
    end

    // R10: glitch shorter than the filter
    speed_od = 1'b0; wt(2);
    u0 = n_used;
    @(negedge clk); mlow = 1'b1; @(negedge clk); mlow = 1'b0;
    wt(5);
    chk(n_used == u0, "R10 glitch ignored", n_used - u0, 0);

    // R7 / R2: low past abort but short of reset
    a0 = n_abort; r0 = n_rst;
    mlow = 1'b1; wt(200); mlow = 1'b0; wt(5);
    chk(n_abort == a0 + 1, "R7 std abort once", n_abort - a0, 1);
    chk(n_rst == r0, "R2 short low is no reset", n_rst - r0, 0);
    speed_od = 1'b1; wt(2);
    a0 = n_abort;
    mlow = 1'b1; wt(20); mlow = 1'b0; wt(5);
    chk(n_abort == a0 + 1, "R7 R9 od abort once", n_abort - a0, 1);

    // R8: sleep and abort in the same cycle
    speed_od = 1'b0; sleep_en = 1'b1; wt(2);
    a0 = n_abort; s0 = n_sleep;
    mlow = 1'b1; wt(130); mlow = 1'b0; wt(5);
    chk(n_sleep == s0 + 1, "R8 sleep request once", n_sleep - s0, 1);
    chk(n_abort == a0 + 1, "R7 abort with sleep", n_abort - a0, 1);
    chk(abort_cyc == sleep_cyc, "R8 R7 same cycle", sleep_cyc, abort_cyc);
    sleep_en = 1'b0; wt(2);
    a0 = n_abort; s0 = n_sleep;
    mlow = 1'b1; wt(130); mlow = 1'b0; wt(5);
    chk(n_sleep == s0, "R8 sleep disabled", n_sleep - s0, 0);
    chk(n_abort == a0 + 1, "R7 abort without sleep", n_abort - a0, 1);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule